// File: doc/BRIEF.md
# Cascadable Event Counter Group

This block holds a small set of event counters that share one register port. Each counter adds one for every clock cycle in which its own event line is high, as long as its control word allows it. A counter that reaches its top value wraps to zero, keeps counting, and raises a sticky overflow flag. That flag stays up until software clears it.

A counter can also be put in cascade mode. In this mode it counts only while its fixed partner's overflow flag is set. Nested measurements are built this way: for example, "events seen after the first counter has overflowed". Counters 0 and 2 are partners, and so are counters 1 and 3. Either member of these two pairs may be the one that waits. An optional fifth and sixth counter are allowed to wait only on counters 2 and 3, and never the other way round.

Software reaches every counter value and every control word through one write strobe and one address. Read data comes back on a registered output.

Top module: `evc_group`

## Requirements
- R1: After reset, every counter value and every control word reads as zero.
- R2: A counter with enable (control bit 0) set and cascade (control bit 1) clear adds exactly one on each clock edge where its event line is high. Event lines of other counters do not change it.
- R3: One increment past the all-ones value gives zero. The same edge sets the overflow flag (control bit 2), and counting goes on from zero.
- R4: The overflow flag is sticky. Writing a control word with bit 2 at 1 clears it. Writing bit 2 at 0 leaves it as it is. A wrap on the same edge as a clear leaves it set.
- R5: A counter whose enable bit is clear keeps its value whatever its event line does.
- R6: A counter with enable and cascade both set counts only while its partner's overflow flag is already set. The edge on which the partner wraps is not counted.
- R7: Clearing the partner's overflow flag stops a cascaded counter.
- R8: Counters 0 and 2 are partners, and 1 and 3 are partners, in either direction. Both chains work at the same time and do not affect each other.
- R9: Counter 4 waits only on counter 2, and counter 5 waits only on counter 3. Counters 2 and 3 in cascade mode depend on counters 0 and 1 only, never on counters 4 or 5.
- R10: A value write to a counter wins over an increment on the same edge.
- R11: The address is formed as {index, select}. Select 0 addresses the counter value and select 1 addresses the control word. Read data shows the addressed word one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NCNT | One event pulse line per counter |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | AW | {counter index, select} |
| reg_wdata | input | CW | Write data (value, or control bits 2:0) |
| reg_rdata | output | CW | Registered read data |

## Verification
The counting path is driven with a single counter's event line alone, with idle gaps, and with all event lines active at once. Together these separate a correct per-counter gate from crosstalk between counters. Preloaded values near the all-ones point confirm the wrap and the flag edge. Cascade chains are run forward (0 to 2) and reverse (2 to 0, 3 to 1) together, which shows whether the partner map really works both ways. A case with counter 4 overflowed while counter 0 is clear shows that counter 2 never looks at counter 4. A write made while an event is high shows which of write and increment wins.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned CAS_BIT = 1;
  localparam int unsigned OVF_BIT = 2;

  typedef struct packed {
    logic ovf;
    logic cas;
    logic en;
  } evc_ctl_t;

  // Fixed partner map: 0<->2, 1<->3, 4<-2, 5<-3
  function automatic int unsigned partner_of(input int unsigned idx);
    if (idx < 4) return idx ^ 2;
    else         return idx - 2;
  endfunction
endpackage

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int unsigned CW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt,
  input  logic          partner_ovf,
  input  logic          val_we,
  input  logic          ctl_we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt_o,
  output evc_ctl_t      ctl_o
);
  logic [CW-1:0] cnt_q;
  evc_ctl_t      ctl_q;
  logic          gate, inc, wrap;

  // gate uses stored flags only: partner wrap edge is not counted
  assign gate = ctl_q.en & (~ctl_q.cas | partner_ovf);
  assign inc  = gate & evt;
  assign wrap = inc & (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ctl_q <= '0;
    end else begin
      if (val_we)   cnt_q <= wdata;
      else if (inc) cnt_q <= cnt_q + 1'b1;
      if (ctl_we) begin
        ctl_q.en  <= wdata[EN_BIT];
        ctl_q.cas <= wdata[CAS_BIT];
      end
      if (wrap && !val_we)             ctl_q.ovf <= 1'b1;
      else if (ctl_we && wdata[OVF_BIT]) ctl_q.ovf <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ctl_o = ctl_q;

  p_wrap_sets_ovf_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.en && !ctl_q.cas && evt && (&cnt_q) && !val_we) |=> (cnt_q == '0 && ctl_q.ovf));
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.ovf && !(ctl_we && wdata[OVF_BIT])) |=> ctl_q.ovf);
  p_disabled_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.en && !val_we) |=> $stable(cnt_q));
  p_cascade_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.cas && !partner_ovf && !val_we) |=> $stable(cnt_q));
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    val_we |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/evc_regport.sv
module evc_regport
  import evc_pkg::*;
#(
  parameter int unsigned NCNT = 6,
  parameter int unsigned CW   = 40,
  localparam int unsigned IW  = $clog2(NCNT),
  localparam int unsigned AW  = IW + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic [AW-1:0]           reg_addr,
  input  logic [NCNT-1:0][CW-1:0] cnt_i,
  input  evc_ctl_t [NCNT-1:0]     ctl_i,
  output logic [NCNT-1:0]         val_we,
  output logic [NCNT-1:0]         ctl_we,
  output logic [CW-1:0]           rdata
);
  logic [IW-1:0] idx;
  logic          sel;
  logic [CW-1:0] rd_next;

  assign idx = reg_addr[AW-1:1];
  assign sel = reg_addr[0];

  always_comb begin
    val_we = '0;
    ctl_we = '0;
    for (int i = 0; i < NCNT; i++) begin
      if (reg_we && (idx == IW'(i))) begin
        val_we[i] = ~sel;
        ctl_we[i] = sel;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCNT; i++) begin
      if (idx == IW'(i)) begin
        if (sel) rd_next = {{(CW-3){1'b0}}, ctl_i[i]};
        else     rd_next = cnt_i[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  p_one_target_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({val_we, ctl_we}));
endmodule

// File: rtl/evc_group.sv
module evc_group
  import evc_pkg::*;
#(
  parameter int unsigned NCNT = 6,
  parameter int unsigned CW   = 40,
  localparam int unsigned IW  = $clog2(NCNT),
  localparam int unsigned AW  = IW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCNT-1:0] evt_i,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [CW-1:0]   reg_wdata,
  output logic [CW-1:0]   reg_rdata
);
  logic [NCNT-1:0][CW-1:0] cnt;
  evc_ctl_t [NCNT-1:0]     ctl;
  logic [NCNT-1:0]         val_we, ctl_we, p_ovf;

  evc_regport #(.NCNT(NCNT), .CW(CW)) u_port (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .cnt_i(cnt), .ctl_i(ctl), .val_we(val_we), .ctl_we(ctl_we),
    .rdata(reg_rdata)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    localparam int unsigned PRT = partner_of(g);
    assign p_ovf[g] = ctl[PRT].ovf;

    evc_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .evt(evt_i[g]), .partner_ovf(p_ovf[g]),
      .val_we(val_we[g]), .ctl_we(ctl_we[g]), .wdata(reg_wdata),
      .cnt_o(cnt[g]), .ctl_o(ctl[g])
    );
  end

  initial begin
    p_count_even_r8: assert (NCNT == 4 || NCNT == 6);
  end
endmodule

// File: tb/sim_evc_group.sv
module sim_evc_group;
  localparam int unsigned NCNT = 6;
  localparam int unsigned CW   = 40;
  localparam int unsigned AW   = $clog2(NCNT) + 1;
  localparam logic [CW-1:0] MAXV = '1;

  logic clk = 0, rst = 1, reg_we = 0;
  logic [NCNT-1:0] evt_i = '0;
  logic [AW-1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0, reg_rdata;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  evc_group #(.NCNT(NCNT), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .evt_i(evt_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; evt_i = '0; reg_we = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic wr(input int idx, input bit sel, input logic [CW-1:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'({idx[AW-2:0], sel}); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int idx, input bit sel, output logic [CW-1:0] v);
    @(negedge clk);
    reg_addr = AW'({idx[AW-2:0], sel});
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic pulse(input logic [NCNT-1:0] m, input int n);
    @(negedge clk); evt_i = m;
    repeat (n) @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [CW-1:0] v;
    for (int i = 0; i < NCNT; i++) begin
      rd(i, 0, v); check("R1 value after reset", v, 0);
      rd(i, 1, v); check("R1 control after reset", v, 0);
    end
  endtask

  task automatic t_count();
    logic [CW-1:0] v;
    do_reset();
    wr(0, 1, 1);
    pulse(6'b000001, 7);
    rd(0, 0, v); check("R2 seven events", v, 7);
    repeat (3) @(negedge clk);
    rd(0, 0, v); check("R2 idle holds", v, 7);
    pulse(6'b111110, 4);
    rd(0, 0, v); check("R2 other lines ignored", v, 7);
  endtask

  task automatic t_wrap();
    logic [CW-1:0] v;
    wr(1, 1, 1);
    wr(1, 0, MAXV - 2);
    pulse(6'b000010, 4);
    rd(1, 0, v); check("R3 wrapped value", v, 1);
    rd(1, 1, v); check("R3 overflow set", v, 5);
    wr(1, 1, 1);
    rd(1, 1, v); check("R4 write 0 keeps flag", v, 5);
    pulse(6'b000010, 2);
    rd(1, 1, v); check("R4 sticky after counting", v, 5);
    rd(1, 0, v); check("R3 counts on after wrap", v, 3);
    wr(1, 1, 5);
    rd(1, 1, v); check("R4 write 1 clears", v, 1);
    wr(1, 1, 0);
    pulse(6'b000010, 4);
    rd(1, 0, v); check("R5 disabled holds", v, 3);
  endtask

  task automatic t_priority();
    logic [CW-1:0] v;
    @(negedge clk); evt_i = 6'b000001;
    reg_we = 1; reg_addr = AW'({3'd0, 1'b0}); reg_wdata = 100;
    @(negedge clk); reg_we = 0; evt_i = '0;
    rd(0, 0, v); check("R10 write beats increment", v, 100);
  endtask

  task automatic t_cascade_fwd();
    logic [CW-1:0] v;
    do_reset();
    wr(0, 0, MAXV - 1); wr(0, 1, 1);
    wr(2, 1, 3);
    pulse(6'b000101, 5);
    rd(2, 0, v); check("R6 cascaded count after partner wrap", v, 3);
    rd(0, 0, v); check("R11 counter 0 value", v, 3);
    wr(0, 1, 5);
    pulse(6'b000101, 2);
    rd(2, 0, v); check("R7 stopped by partner clear", v, 3);
    rd(0, 0, v); check("R7 partner still counts", v, 5);
  endtask

  task automatic t_cascade_rev();
    logic [CW-1:0] v;
    do_reset();
    wr(2, 0, MAXV); wr(2, 1, 1);
    wr(3, 0, MAXV - 1); wr(3, 1, 1);
    wr(0, 1, 3); wr(1, 1, 3);
    pulse(6'b001111, 4);
    rd(0, 0, v); check("R8 counter 0 waits on 2", v, 3);
    rd(1, 0, v); check("R8 counter 1 waits on 3", v, 2);
  endtask

  task automatic t_extra();
    logic [CW-1:0] v;
    do_reset();
    wr(4, 0, MAXV); wr(4, 1, 1);
    wr(2, 1, 3);
    pulse(6'b010100, 3);
    rd(4, 1, v); check("R9 counter 4 overflowed", v, 5);
    rd(2, 0, v); check("R9 counter 2 ignores counter 4", v, 0);
    wr(3, 0, MAXV); wr(3, 1, 1);
    wr(5, 1, 3);
    pulse(6'b101000, 3);
    rd(5, 0, v); check("R9 counter 5 waits on 3", v, 2);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_count();
    t_wrap();
    t_priority();
    t_cascade_fwd();
    t_cascade_rev();
    t_extra();
    do_reset();
    t_reset();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL R1-watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule